// File: doc/BRIEF.md
# Periodic SPI Temperature Sampler

This block is a receive-only SPI master for a temperature converter that only talks back. On request it opens a transaction: chip select drops, the serial clock pulses once for each bit of the frame, and the converter's serial output is shifted in. When chip select returns high, the full raw frame and its leading temperature field are presented in parallel, together with a one-cycle valid strobe.

Everything runs on the system clock. The serial clock is not a separate clock. It is a registered output from a single sequencing counter, which also drives chip select. The transaction is split into slots of `CLK_DIV` system cycles each:

- one guard slot with chip select low and the serial clock idle;
- `FRAME_BITS` slots that each carry one clock pulse;
- one trailing idle slot;
- `GAP_SLOTS` slots with chip select high.

Because of this schedule the serial clock is low at both chip-select edges. A start request is taken only when the counter is parked at the end of the gap. A parameter can tie the request high so that the block samples continuously.

Top module: `thermo_spi_sampler`

## Requirements
- R1: While reset is high, and on the first cycle after it, csN is 1, sck is 0, valid is 0, and frame and temp are all zeros. A reset in the middle of a transaction aborts it.
- R2: When start is high at a rising edge while the block is idle, csN goes low on the second rising edge after that one. It then stays low for (FRAME_BITS+2)*CLK_DIV system cycles.
- R3: Each transaction has exactly FRAME_BITS sck pulses. Each pulse is high for CLK_DIV/2 cycles, and sck is never high while csN is high.
- R4: The first sck rise comes CLK_DIV + CLK_DIV/2 cycles after csN falls. csN rises CLK_DIV cycles after the last sck fall.
- R5: sck is 0 on the cycle before and the cycle after every csN transition.
- R6: miso is sampled at each sck falling edge and shifted in MSB first. Frame bit FRAME_BITS-1 is the level miso shows before the first falling edge, and bit 0 is the level before the last falling edge.
- R7: temp equals frame bits FRAME_BITS-1 down to FRAME_BITS-TEMP_BITS (bits 31..18 by default).
- R8: valid is high for exactly one cycle per transaction, namely the first cycle in which csN reads high again. frame and temp already carry the new word in that cycle and hold it until the next transaction ends.
- R9: A start that arrives while a transaction or its gap is in progress is ignored, and no extra chip-select window follows.
- R10: If start is held high, transactions run back to back, and csN stays high for exactly GAP_SLOTS*CLK_DIV cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transaction request, taken only when idle |
| miso | input | 1 | Serial data from the converter |
| sck | output | 1 | Serial clock, idle low |
| csN | output | 1 | Chip select, active low |
| frame | output | FRAME_BITS | Last complete raw frame |
| temp | output | TEMP_BITS | Leading temperature field of the frame |
| valid | output | 1 | One-cycle strobe when frame and temp update |

## Verification
A sequencing counter that is off by one slot or one phase shows up at the pins within one transaction:

- the guard or trailing interval shrinks or grows by CLK_DIV cycles;
- the number of serial clock pulses is not FRAME_BITS;
- the chip-select edge lands on a cycle where sck is high.

A wrong shift direction or sample point garbles the frame. The corruption becomes visible at the valid strobe, which follows the closing chip-select edge in the same cycle. A launch condition that accepts requests while busy shows up as a second chip-select window inside a single request window.

// File: rtl/thermo_spi_pkg.sv
package thermo_spi_pkg;

  // Strobes passed from the sequencer to the receive datapath
  typedef struct packed {
    logic shiftEn;  // take one miso bit (coincides with an sck fall)
    logic latchEn;  // move assembled word to the outputs (coincides with csN rise)
  } spiStrobes_t;

endpackage

// File: rtl/thermo_spi_ctrl.sv
module thermo_spi_ctrl
  import thermo_spi_pkg::*;
#(
  parameter int CLK_DIV    = 10,
  parameter int FRAME_BITS = 32,
  parameter int GAP_SLOTS  = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  output logic        csN,
  output logic        sckOut,
  output spiStrobes_t strobes
);

  localparam int HALF_DIV  = CLK_DIV / 2;
  localparam int TRAIL     = FRAME_BITS + 1;
  localparam int LAST_SLOT = FRAME_BITS + 1 + GAP_SLOTS;
  localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
  localparam int PH_W      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  localparam logic [SLOT_W-1:0] SLOT_FIRST_PULSE = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_LAST_PULSE  = SLOT_W'(FRAME_BITS);
  localparam logic [SLOT_W-1:0] SLOT_TRAIL       = SLOT_W'(TRAIL);
  localparam logic [SLOT_W-1:0] SLOT_PARK        = SLOT_W'(LAST_SLOT);
  localparam logic [PH_W-1:0]   PH_LAST          = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0]   PH_HALF          = PH_W'(HALF_DIV);

  logic [SLOT_W-1:0] slotCnt;
  logic [PH_W-1:0]   phaseCnt;
  logic              idle;
  logic              launch;
  logic              csLowNext;
  logic              sckHighNext;

  // The counter parks on the last phase of the last gap slot
  assign idle   = (slotCnt == SLOT_PARK) && (phaseCnt == PH_LAST);
  assign launch = idle && startReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt  <= SLOT_PARK;
      phaseCnt <= PH_LAST;
    end else if (launch) begin
      slotCnt  <= '0;
      phaseCnt <= '0;
    end else if (!idle) begin
      if (phaseCnt == PH_LAST) begin
        phaseCnt <= '0;
        slotCnt  <= slotCnt + SLOT_W'(1);
      end else begin
        phaseCnt <= phaseCnt + PH_W'(1);
      end
    end
  end

  // Decode the slot into pin levels; the pins are registered one cycle later
  assign csLowNext   = (slotCnt <= SLOT_TRAIL);
  assign sckHighNext = (slotCnt >= SLOT_FIRST_PULSE) && (slotCnt <= SLOT_LAST_PULSE)
                       && (phaseCnt >= PH_HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      csN    <= 1'b1;
      sckOut <= 1'b0;
    end else begin
      csN    <= !csLowNext;
      sckOut <= sckHighNext;
    end
  end

  // Strobes fire on the cycle whose edge moves the pin
  assign strobes.shiftEn = sckOut && !sckHighNext;
  assign strobes.latchEn = !csN && csLowNext == 1'b0;

  // R5
  sck_low_at_cs_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(csN) || $fell(csN)) |-> (!sckOut && !$past(sckOut)));

  // R3
  sck_inside_select_chk: assert property (@(posedge clk) disable iff (rst)
    sckOut |-> !csN);

  // R2
  cs_fall_after_launch_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> $past(launch, 2));

  // R1
  ctrl_reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csN && !sckOut));

endmodule

// File: rtl/thermo_spi_datapath.sv
module thermo_spi_datapath
  import thermo_spi_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int TEMP_BITS  = 14
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miso,
  input  spiStrobes_t           strobes,
  output logic [FRAME_BITS-1:0] frameOut,
  output logic [TEMP_BITS-1:0]  tempOut,
  output logic                  validOut
);

  logic [FRAME_BITS-1:0] shiftReg;

  // MSB first: the earliest bit ends up at the top after a full frame
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frameOut <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= strobes.latchEn;
      if (strobes.latchEn) begin
        frameOut <= shiftReg;
      end
    end
  end

  assign tempOut = frameOut[FRAME_BITS-1 -: TEMP_BITS];

  // R8
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);

  // R1
  dp_reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!validOut && frameOut == '0));

endmodule

// File: rtl/thermo_spi_sampler.sv
module thermo_spi_sampler
  import thermo_spi_pkg::*;
#(
  parameter int CLK_DIV    = 10,
  parameter int FRAME_BITS = 32,
  parameter int TEMP_BITS  = 14,
  parameter int GAP_SLOTS  = 1,
  parameter bit FREE_RUN   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  miso,
  output logic                  sck,
  output logic                  csN,
  output logic [FRAME_BITS-1:0] frame,
  output logic [TEMP_BITS-1:0]  temp,
  output logic                  valid
);

  spiStrobes_t strobes;
  logic        startReq;

  assign startReq = start || FREE_RUN;

  thermo_spi_ctrl #(
    .CLK_DIV    (CLK_DIV),
    .FRAME_BITS (FRAME_BITS),
    .GAP_SLOTS  (GAP_SLOTS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .csN      (csN),
    .sckOut   (sck),
    .strobes  (strobes)
  );

  thermo_spi_datapath #(
    .FRAME_BITS (FRAME_BITS),
    .TEMP_BITS  (TEMP_BITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .miso     (miso),
    .strobes  (strobes),
    .frameOut (frame),
    .tempOut  (temp),
    .validOut (valid)
  );

  // R8
  valid_on_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(csN) |-> valid);

  // R6
  shift_while_selected_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |-> !csN);

endmodule

// File: tb/thermo_spi_sampler_test.sv
`timescale 1ns/1ps
module thermo_spi_sampler_test;

  localparam int CLK_PERIOD = 20;
  localparam int DIV        = 10;
  localparam int FB         = 32;
  localparam int TB         = 14;
  localparam int GAP        = 1;
  localparam int HALF       = DIV / 2;
  localparam int CS_LOW     = (FB + 2) * DIV;
  localparam int WIN        = (FB + 2 + GAP + 5) * DIV;
  localparam int NVEC       = 7;

  // {frame sent by the slave, expected temperature field}
  localparam logic [FB+TB-1:0] VECS [NVEC] = '{
    {32'h0000_0000, 14'h0000},
    {32'hFFFF_FFFF, 14'h3FFF},
    {32'h8000_0001, 14'h2000},
    {32'hAAAA_5555, 14'h2AAA},
    {32'h1234_ABCD, 14'h048D},
    {32'hFFFC_0000, 14'h3FFF},
    {32'h0003_FFFF, 14'h0000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          miso = 1'b1;
  logic          sck;
  logic          csN;
  logic [FB-1:0] frame;
  logic [TB-1:0] temp;
  logic          valid;
  logic [FB-1:0] slaveWord = '0;

  int nChecks = 0;
  int nFail   = 0;

  thermo_spi_sampler #(
    .CLK_DIV(DIV), .FRAME_BITS(FB), .TEMP_BITS(TB), .GAP_SLOTS(GAP), .FREE_RUN(1'b0)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .miso(miso), .sck(sck), .csN(csN),
    .frame(frame), .temp(temp), .valid(valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Converter model: first bit appears when selected, next bit after every sck fall
  initial begin
    logic [FB-1:0] w;
    int b;
    forever begin
      @(negedge csN);
      w = slaveWord;
      b = FB - 1;
      miso = w[b];
      while (csN == 1'b0) begin
        @(negedge sck or posedge csN);
        if (csN == 1'b0) begin
          #1;
          b--;
          miso = (b >= 0) ? w[b] : 1'b0;
        end
      end
      miso = 1'b1;
    end
  end

  task automatic run_txn(input logic [FB-1:0] word, input logic [TB-1:0] expTemp, input bit poke);
    int csFall = -1, csRise = -1, firstRise = -1, lastHigh = -1;
    int lowCnt = 0, rises = 0, highCnt = 0, falls = 0, validCnt = 0, validIdx = -1;
    int badOverlap = 0, badEdge = 0;
    logic prevCs = 1'b1, prevSck = 1'b0;
    logic [FB-1:0] capFrame = '0;
    logic [TB-1:0] capTemp = '0;
    slaveWord = word;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < WIN; k++) begin
      if (k > 0) @(negedge clk);
      start = (poke && (k == 200 || k == 342)) ? 1'b1 : 1'b0;
      if (csN != prevCs) begin
        if (sck || prevSck) badEdge++;
        if (!csN) begin falls++; if (csFall < 0) csFall = k; end
        else if (csRise < 0) csRise = k;
      end
      if (!csN) lowCnt++;
      if (sck && csN) badOverlap++;
      if (sck) begin
        highCnt++; lastHigh = k;
        if (!prevSck) begin rises++; if (firstRise < 0) firstRise = k; end
      end
      if (valid) begin validCnt++; validIdx = k; capFrame = frame; capTemp = temp; end
      prevCs = csN; prevSck = sck;
    end
    start = 1'b0;
    chk(csFall == 1, "R2 launch delay", csFall, 1);
    chk(lowCnt == CS_LOW, "R2 cs low length", lowCnt, CS_LOW);
    chk(rises == FB, "R3 pulse count", rises, FB);
    chk(highCnt == FB * HALF, "R3 high cycles", highCnt, FB * HALF);
    chk(badOverlap == 0, "R3 sck with cs high", badOverlap, 0);
    chk(firstRise - csFall == DIV + HALF, "R4 guard", firstRise - csFall, DIV + HALF);
    chk(csRise - (lastHigh + 1) == DIV, "R4 trailing", csRise - (lastHigh + 1), DIV);
    chk(badEdge == 0, "R5 sck at cs edge", badEdge, 0);
    chk(validCnt == 1, "R8 valid count", validCnt, 1);
    chk(validIdx == csRise, "R8 valid timing", validIdx, csRise);
    chk(capFrame == word, "R6 frame", capFrame, word);
    chk(capTemp == expTemp, "R7 temp", capTemp, expTemp);
    chk(frame == word, "R8 frame hold", frame, word);
    chk(falls == 1, "R9 single window", falls, 1);
    if (poke) chk(csN == 1'b1, "R9 no late launch", csN, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int rise1, fall2, vcnt;
    logic prevCs;
    logic [FB-1:0] last;
    repeat (5) @(negedge clk);
    // R1 in reset
    chk(csN == 1'b1 && sck == 1'b0 && valid == 1'b0, "R1 pins in reset", {csN, sck, valid}, 3'b100);
    chk(frame == '0 && temp == '0, "R1 data in reset", frame, 0);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++)
      run_txn(VECS[v][FB+TB-1:TB], VECS[v][TB-1:0], 1'b0);

    // R9: requests during transfer and gap
    run_txn(32'hC0DE_F00D, 14'h3037, 1'b1);

    // R10: start held high, back-to-back
    slaveWord = 32'h5A5A_C3C3;
    rise1 = -1; fall2 = -1; vcnt = 0; prevCs = 1'b1; last = '0;
    @(negedge clk); start = 1'b1;
    for (int k = 0; k < 2 * WIN - 40; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 360) start = 1'b0;
      if (csN && !prevCs && rise1 < 0) rise1 = k;
      if (!csN && prevCs && rise1 >= 0 && fall2 < 0) fall2 = k;
      if (valid) begin vcnt++; last = frame; end
      prevCs = csN;
    end
    chk(fall2 - rise1 == GAP * DIV, "R10 gap", fall2 - rise1, GAP * DIV);
    chk(vcnt == 2, "R10 frames", vcnt, 2);
    chk(last == 32'h5A5A_C3C3, "R10 frame", last, 32'h5A5A_C3C3);

    // R1: reset in the middle of a transaction
    slaveWord = 32'h0F0F_0F0F;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1 && sck == 1'b0 && valid == 1'b0, "R1 abort pins", {csN, sck, valid}, 3'b100);
    chk(frame == '0 && temp == '0, "R1 abort data", frame, 0);
    @(negedge clk); rst = 1'b0;
    run_txn(32'h8765_4321, 14'h21D9, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule